// File: doc/BRIEF.md
# Slot Power Limit Message Controller

This block sits in a root port and sends a slot power limit message request by itself each time the data link layer comes up. It holds a control register with an 8-bit limit value, a 2-bit scale and a send-enable flag. When the registered link-up input moves from low to high and send-enable is set, the block raises a single-cycle request that carries the value and scale. A downstream packet builder turns that request into the actual message.

Software reaches the block through a small word-addressed register port with byte enables. The port exposes four words: the raw control register, a combined slot control and slot status word, a read-only slot capabilities word, and an unused word.

In the slot control word, the automatic-limit-disable bit behaves as the inverse of send-enable, but only while a non-zero limit value is configured. While the value is zero, that bit is only a stored flag with no effect. Two one-cycle commands load the register and clear it:

- The setup command clears everything first. It then loads the value and scale with send-enable set, but only when the value is non-zero.
- The teardown command clears value, scale and enable.

Top module: `slot_pwr_msg_ctrl`

## Requirements
- R1: After reset every control field (value, scale, enable) and the stored disable flag are 0, `msg_valid` is 0 and `msg_value`/`msg_scale` are 0.
- R2: Word address 0 is the control register. The value is at bits 7:0, the scale at bits 9:8 and send-enable at bit 16. All other bits read 0. A write updates only the byte lanes whose `cfg_be` bit is set.
- R3: A `setup_go` pulse first clears value, scale and enable. It then loads `setup_value`, `setup_scale` and enable=1 only if `setup_value` is non-zero, so a zero `setup_value` leaves all three at 0.
- R4: A `teardown_go` pulse clears value, scale and enable. It takes priority over `setup_go` and over a register write in the same cycle.
- R5: If `dl_up` is sampled 0 at one rising edge and 1 at the next while send-enable is 1, then `msg_valid` is 1 for exactly the one cycle that follows the edge after that.
- R6: No request is issued while send-enable is 0, and a `dl_up` level held high never issues a second request.
- R7: While `msg_valid` is 1, `msg_value` and `msg_scale` equal the control value and scale that held when the link-up edge was detected, and they keep those values until the next request.
- R8: Word address 1 reads slot control in bits 15:0 and slot status in bits 31:16. Bit 22 (presence detect, status bit 6) always reads 1. Bit 13 (automatic-limit-disable) reads the stored flag when the value is zero, and otherwise the inverse of send-enable. All other bits read 0.
- R9: A write to address 1 with `cfg_be[1]` set always stores `cfg_wdata[13]` in the disable flag. When the value is non-zero, it also sets send-enable to the inverse of `cfg_wdata[13]`. With `cfg_be[1]` clear the write has no effect.
- R10: Word address 2 reads the slot capabilities. The value is at bits 14:7, the scale at bits 16:15 and the slot number `PORT_INDEX+1` at bits 31:19. All other bits read 0. Writes to address 2 are ignored.
- R11: Word address 3 reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Word address (0 control, 1 slot control/status, 2 slot capabilities, 3 unused) |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| setup_go | input | 1 | One-cycle setup command |
| setup_value | input | 8 | Limit value used by setup |
| setup_scale | input | 2 | Scale used by setup |
| teardown_go | input | 1 | One-cycle teardown command |
| dl_up | input | 1 | Data link layer up level |
| msg_valid | output | 1 | One-cycle message request |
| msg_value | output | 8 | Limit value carried by the request |
| msg_scale | output | 2 | Scale carried by the request |

## Verification
The link-up trigger is driven with four patterns:
- a clean rising edge while enabled, which separates correct edge detection from a level response;
- a long held-high level, which exposes retriggering;
- a rising edge after the disable bit was written, which shows whether the slot control path really gates the request;
- a rising edge after a new setup, which shows that the request carries the current value and scale.

The slot control disable bit is written both with a zero and with a non-zero configured value, which separates its stored-only behaviour from its live effect on enable. The commands are driven both singly and together, which shows the priority of teardown.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned BYTES       = DATA_W / 8;
  localparam int unsigned VAL_W       = 8;
  localparam int unsigned SCL_W       = 2;
  localparam int unsigned PSN_W       = 13;

  // control word layout
  localparam int unsigned CTRL_VAL_LSB = 0;
  localparam int unsigned CTRL_SCL_LSB = 8;
  localparam int unsigned CTRL_EN_BIT  = 16;

  // slot control / status word layout
  localparam int unsigned SLT_DIS_BIT  = 13;
  localparam int unsigned SLT_DIS_LANE = SLT_DIS_BIT / 8;
  localparam int unsigned STA_PDS_BIT  = 16 + 6;

  // slot capabilities word layout
  localparam int unsigned CAP_VAL_LSB  = 7;
  localparam int unsigned CAP_SCL_LSB  = 15;
  localparam int unsigned CAP_PSN_LSB  = 19;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_SLOT = 2'd1,
    A_CAP  = 2'd2,
    A_NONE = 2'd3
  } spl_addr_e;

  typedef struct packed {
    logic             en;
    logic [SCL_W-1:0] scale;
    logic [VAL_W-1:0] value;
  } spl_cfg_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(input spl_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_VAL_LSB +: VAL_W] = c.value;
    w[CTRL_SCL_LSB +: SCL_W] = c.scale;
    w[CTRL_EN_BIT]           = c.en;
    return w;
  endfunction

  function automatic spl_cfg_t ctrl_unpack(input logic [DATA_W-1:0] w);
    spl_cfg_t c;
    c.value = w[CTRL_VAL_LSB +: VAL_W];
    c.scale = w[CTRL_SCL_LSB +: SCL_W];
    c.en    = w[CTRL_EN_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cap_pack(input spl_cfg_t c,
                                                 input logic [PSN_W-1:0] psn);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CAP_VAL_LSB +: VAL_W] = c.value;
    w[CAP_SCL_LSB +: SCL_W] = c.scale;
    w[CAP_PSN_LSB +: PSN_W] = psn;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] slot_pack(input logic dis_bit);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SLT_DIS_BIT] = dis_bit;
    w[STA_PDS_BIT] = 1'b1;
    return w;
  endfunction

  // disable bit as seen by software: stored flag when no limit, else ~enable
  function automatic logic dis_view(input spl_cfg_t c, input logic flag);
    return (c.value == '0) ? flag : ~c.en;
  endfunction

endpackage

// File: rtl/spl_cfg_regs.sv
module spl_cfg_regs
  import spl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_slot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTES-1:0]  be,
  input  logic              setup_go,
  input  logic [VAL_W-1:0]  setup_value,
  input  logic [SCL_W-1:0]  setup_scale,
  input  logic              teardown_go,
  output spl_cfg_t          cfg,
  output logic              dis_flag
);

  spl_cfg_t          cfg_q, cfg_d;
  logic              flag_q;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] merged;
  logic              slot_lane_hit;

  assign cur_word = ctrl_pack(cfg_q);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : cur_word[8*b +: 8];
  end

  assign slot_lane_hit = wr_slot && be[SLT_DIS_LANE];

  always_comb begin
    cfg_d = cfg_q;
    if (teardown_go) begin
      cfg_d = '0;
    end else if (setup_go) begin
      cfg_d = '0;
      if (setup_value != '0) begin
        cfg_d.value = setup_value;
        cfg_d.scale = setup_scale;
        cfg_d.en    = 1'b1;
      end
    end else if (wr_ctrl) begin
      cfg_d = ctrl_unpack(merged);
    end else if (slot_lane_hit && (cfg_q.value != '0)) begin
      cfg_d.en = ~wdata[SLT_DIS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      if (slot_lane_hit) flag_q <= wdata[SLT_DIS_BIT];
    end
  end

  assign cfg      = cfg_q;
  assign dis_flag = flag_q;

endmodule

// File: rtl/spl_link_trig.sv
module spl_link_trig
  import spl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dl_up,
  input  spl_cfg_t         cfg,
  output logic             link_rise,
  output logic             msg_valid,
  output logic [VAL_W-1:0] msg_value,
  output logic [SCL_W-1:0] msg_scale
);

  logic dl_s, dl_q;
  logic fire;

  assign link_rise = dl_s && !dl_q;
  assign fire      = link_rise && cfg.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_s      <= 1'b0;
      dl_q      <= 1'b0;
      msg_valid <= 1'b0;
      msg_value <= '0;
      msg_scale <= '0;
    end else begin
      dl_s      <= dl_up;
      dl_q      <= dl_s;
      msg_valid <= fire;
      if (fire) begin
        msg_value <= cfg.value;
        msg_scale <= cfg.scale;
      end
    end
  end

endmodule

// File: rtl/spl_view.sv
module spl_view
  import spl_pkg::*;
#(
  parameter int unsigned PORT_INDEX = 0
) (
  input  spl_cfg_t          cfg,
  input  logic              dis_flag,
  input  spl_addr_e         addr,
  output logic              dis_read,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [PSN_W-1:0] SLOT_NUM = PSN_W'(PORT_INDEX + 1);

  assign dis_read = dis_view(cfg, dis_flag);

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = ctrl_pack(cfg);
      A_SLOT:  rdata = slot_pack(dis_read);
      A_CAP:   rdata = cap_pack(cfg, SLOT_NUM);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/slot_pwr_msg_ctrl.sv
module slot_pwr_msg_ctrl
  import spl_pkg::*;
#(
  parameter int unsigned PORT_INDEX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  input  logic        setup_go,
  input  logic [7:0]  setup_value,
  input  logic [1:0]  setup_scale,
  input  logic        teardown_go,
  input  logic        dl_up,
  output logic        msg_valid,
  output logic [7:0]  msg_value,
  output logic [1:0]  msg_scale
);

  spl_addr_e addr_e;
  spl_cfg_t  cfg_w;
  logic      wr_ctrl_w, wr_slot_w;
  logic      dis_flag_w, dis_read_w;
  logic      link_rise_w;

  // named internal events for the bound checker
  logic       cfg_en_w;
  logic [7:0] cfg_value_w;
  logic [1:0] cfg_scale_w;

  assign addr_e      = spl_addr_e'(cfg_addr);
  assign wr_ctrl_w   = cfg_wr && (addr_e == A_CTRL);
  assign wr_slot_w   = cfg_wr && (addr_e == A_SLOT);
  assign cfg_en_w    = cfg_w.en;
  assign cfg_value_w = cfg_w.value;
  assign cfg_scale_w = cfg_w.scale;

  spl_cfg_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl_w),
    .wr_slot     (wr_slot_w),
    .wdata       (cfg_wdata),
    .be          (cfg_be),
    .setup_go    (setup_go),
    .setup_value (setup_value),
    .setup_scale (setup_scale),
    .teardown_go (teardown_go),
    .cfg         (cfg_w),
    .dis_flag    (dis_flag_w)
  );

  spl_link_trig u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .dl_up     (dl_up),
    .cfg       (cfg_w),
    .link_rise (link_rise_w),
    .msg_valid (msg_valid),
    .msg_value (msg_value),
    .msg_scale (msg_scale)
  );

  spl_view #(.PORT_INDEX(PORT_INDEX)) u_view (
    .cfg      (cfg_w),
    .dis_flag (dis_flag_w),
    .addr     (addr_e),
    .dis_read (dis_read_w),
    .rdata    (cfg_rdata)
  );

endmodule

// File: rtl/slot_pwr_msg_ctrl_chk.sv
module slot_pwr_msg_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        setup_go,
  input logic [7:0]  setup_value,
  input logic        teardown_go,
  input logic [1:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        link_rise,
  input logic        cfg_en,
  input logic [7:0]  cfg_value,
  input logic [1:0]  cfg_scale,
  input logic        msg_valid,
  input logic [7:0]  msg_value,
  input logic [1:0]  msg_scale
);

  // R4: teardown empties the control fields on the next cycle
  a_r4_teardown_clears: assert property (@(posedge clk) disable iff (!rst_n)
    teardown_go |=> (cfg_value == 8'd0 && cfg_scale == 2'd0 && !cfg_en));

  // R3: setup with a zero value leaves enable clear
  a_r3_zero_setup_off: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_go && !teardown_go && setup_value == 8'd0) |=> !cfg_en);

  // R5 / R6: a request needs a detected edge with enable set
  a_r5_needs_edge_and_en: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ($past(link_rise) && $past(cfg_en)));

  // R6: a request never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !$past(msg_valid));

  // R7: payload equals the configuration seen at the edge
  a_r7_payload: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_value == $past(cfg_value) && msg_scale == $past(cfg_scale)));

  // R7: payload holds between requests
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> ($stable(msg_value) && $stable(msg_scale)));

  // R8: presence detect always reads set
  a_r8_presence: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd1) |-> cfg_rdata[22]);

endmodule

bind slot_pwr_msg_ctrl slot_pwr_msg_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_go    (setup_go),
  .setup_value (setup_value),
  .teardown_go (teardown_go),
  .cfg_addr    (cfg_addr),
  .cfg_rdata   (cfg_rdata),
  .link_rise   (link_rise_w),
  .cfg_en      (cfg_en_w),
  .cfg_value   (cfg_value_w),
  .cfg_scale   (cfg_scale_w),
  .msg_valid   (msg_valid),
  .msg_value   (msg_value),
  .msg_scale   (msg_scale)
);

// File: tb/slot_pwr_msg_ctrl_bench.sv
`timescale 1ns/1ps
module slot_pwr_msg_ctrl_bench;

  localparam int PIDX = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        setup_go = 1'b0;
  logic [7:0]  setup_value = '0;
  logic [1:0]  setup_scale = '0;
  logic        teardown_go = 1'b0;
  logic        dl_up = 1'b0;
  logic        msg_valid;
  logic [7:0]  msg_value;
  logic [1:0]  msg_scale;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slot_pwr_msg_ctrl #(.PORT_INDEX(PIDX)) u_slot_pwr_msg_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .setup_go(setup_go), .setup_value(setup_value), .setup_scale(setup_scale),
    .teardown_go(teardown_go), .dl_up(dl_up), .msg_valid(msg_valid),
    .msg_value(msg_value), .msg_scale(msg_scale)
  );

  // ---------------- behavioural reference model ----------------
  int m_val = 0, m_scl = 0, m_en = 0, m_flag = 0;
  int m_seen_prev = 0, m_seen = 0;
  int m_mv = 0, m_mval = 0, m_mscl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_val = 0; m_scl = 0; m_en = 0; m_flag = 0;
      m_seen_prev = 0; m_seen = 0; m_mv = 0; m_mval = 0; m_mscl = 0;
    end else begin
      int n_val, n_scl, n_en;
      // trigger uses state before this edge
      m_mv = (m_seen == 1 && m_seen_prev == 0 && m_en == 1) ? 1 : 0;
      if (m_mv == 1) begin m_mval = m_val; m_mscl = m_scl; end
      m_seen_prev = m_seen;
      m_seen = dl_up ? 1 : 0;
      n_val = m_val; n_scl = m_scl; n_en = m_en;
      if (teardown_go) begin
        n_val = 0; n_scl = 0; n_en = 0;
      end else if (setup_go) begin
        if (setup_value != 0) begin n_val = setup_value; n_scl = setup_scale; n_en = 1; end
        else begin n_val = 0; n_scl = 0; n_en = 0; end
      end else if (cfg_wr && cfg_addr == 2'd0) begin
        if (cfg_be[0]) n_val = cfg_wdata[7:0];
        if (cfg_be[1]) n_scl = cfg_wdata[9:8];
        if (cfg_be[2]) n_en  = cfg_wdata[16];
      end else if (cfg_wr && cfg_addr == 2'd1 && cfg_be[1] && m_val != 0) begin
        n_en = cfg_wdata[13] ? 0 : 1;
      end
      if (cfg_wr && cfg_addr == 2'd1 && cfg_be[1]) m_flag = cfg_wdata[13];
      m_val = n_val; m_scl = n_scl; m_en = n_en;
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      2'd0: r = m_val + (m_scl * 256) + (m_en * 65536);
      2'd1: begin
        r = 32'h0040_0000;
        if ((m_val == 0 && m_flag == 1) || (m_val != 0 && m_en == 0)) r = r + 32'h2000;
      end
      2'd2: r = (m_val * 128) + (m_scl * 32768) + ((PIDX + 1) * 524288);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (cfg_addr)
        2'd0: check("R2 ctrl read", cfg_rdata, model_read(2'd0));
        2'd1: check("R8 slot read", cfg_rdata, model_read(2'd1));
        2'd2: check("R10 cap read", cfg_rdata, model_read(2'd2));
        default: check("R11 empty read", cfg_rdata, model_read(2'd3));
      endcase
      check("R5 msg_valid", {31'd0, msg_valid}, m_mv);
      check("R7 msg payload", {22'd0, msg_scale, msg_value}, m_mscl * 256 + m_mval);
      if (msg_valid) pulses++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
    tick();
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic setup(input logic [7:0] v, input logic [1:0] s);
    setup_go = 1'b1; setup_value = v; setup_scale = s;
    tick();
    setup_go = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  initial begin
    int p0;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd_check("R1 ctrl after reset", 2'd0, 32'h0);
    check("R1 msg after reset", {21'd0, msg_valid, msg_scale, msg_value}, 32'h0);
    rd_check("R1 flag after reset", 2'd1, 32'h0040_0000);

    // R2 full write then single lane
    wr(2'd0, 32'hFFFE_02A5, 4'b1111);
    rd_check("R2 ctrl full write", 2'd0, 32'h0000_02A5);
    wr(2'd0, 32'hFFFF_FFFF, 4'b0001);
    rd_check("R2 ctrl lane0 only", 2'd0, 32'h0000_02FF);
    wr(2'd0, 32'h0001_0000, 4'b0100);
    rd_check("R2 enable lane", 2'd0, 32'h0001_02FF);

    // R5 / R7 edge while enabled, R6 held level
    p0 = pulses;
    dl_up = 1'b1;
    tick(12);
    check("R5 one request on edge", pulses - p0, 1);
    check("R7 payload value/scale", {22'd0, msg_scale, msg_value}, 32'h2FF);

    // R9 disable bit with non-zero value, lane clear first
    wr(2'd1, 32'h0000_2000, 4'b0001);
    rd_check("R9 lane clear no effect", 2'd0, 32'h0001_02FF);
    wr(2'd1, 32'h0000_2000, 4'b0010);
    rd_check("R9 disable clears enable", 2'd0, 32'h0000_02FF);
    rd_check("R8 disable reads set", 2'd1, 32'h0040_2000);

    // R6 edge while disabled
    dl_up = 1'b0; tick(3);
    p0 = pulses;
    dl_up = 1'b1; tick(6);
    check("R6 no request when disabled", pulses - p0, 0);
    wr(2'd1, 32'h0000_0000, 4'b0010);
    rd_check("R9 clear bit sets enable", 2'd0, 32'h0001_02FF);
    rd_check("R8 disable reads clear", 2'd1, 32'h0040_0000);

    // R3 setup loads, zero setup empties
    setup(8'h0A, 2'd1);
    rd_check("R3 setup loads", 2'd0, 32'h0001_010A);
    rd_check("R10 cap fields", 2'd2, 32'h0000_8500 + 32'h0028_0000);
    dl_up = 1'b0; tick(3);
    p0 = pulses;
    dl_up = 1'b1; tick(5);
    check("R5 request after setup", pulses - p0, 1);
    check("R7 payload after setup", {22'd0, msg_scale, msg_value}, 32'h10A);
    setup(8'h00, 2'd3);
    rd_check("R3 zero setup clears", 2'd0, 32'h0);

    // R9 with zero value: only the stored flag moves
    wr(2'd1, 32'h0000_2000, 4'b0010);
    rd_check("R9 flag stored, zero value", 2'd1, 32'h0040_2000);
    rd_check("R9 enable untouched", 2'd0, 32'h0);
    wr(2'd1, 32'h0000_0000, 4'b0010);
    rd_check("R9 flag cleared", 2'd1, 32'h0040_0000);

    // R4 teardown and priority over setup
    setup(8'h19, 2'd3);
    rd_check("R10 cap after setup", 2'd2, (32'h19 << 7) | (32'd3 << 15) | (32'd5 << 19));
    teardown_go = 1'b1; tick(); teardown_go = 1'b0;
    rd_check("R4 teardown clears", 2'd0, 32'h0);
    teardown_go = 1'b1; setup_go = 1'b1; setup_value = 8'h33; setup_scale = 2'd2;
    tick();
    teardown_go = 1'b0; setup_go = 1'b0;
    rd_check("R4 teardown beats setup", 2'd0, 32'h0);

    // R10 / R11 writes ignored
    setup(8'h44, 2'd2);
    wr(2'd2, 32'hFFFF_FFFF, 4'b1111);
    wr(2'd3, 32'hFFFF_FFFF, 4'b1111);
    rd_check("R11 empty word", 2'd3, 32'h0);
    rd_check("R11 ctrl unchanged", 2'd0, 32'h0001_0244);
    tick(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule